// File: doc/BRIEF.md
# Indexed Colour Palette with Register Access

This block is a colour lookup table for a display pipeline. It holds 256 pseudocolour entries and 4 overlay (cursor) entries. Each entry has an 8-bit red, green and blue component. Software programs the table over a 32-bit register bus. It first loads a shared entry index, then moves through the components of successive entries with a three-step red, green, blue sequencer. The index advances by one after every blue access.

A separate pixel port sits on the display side. It takes an 8-bit pixel value or an overlay selection and returns the matching colour as a packed 24-bit word. The result appears one clock after the inputs are presented. Reads over the register bus use the same sequencer as writes, so software can dump the whole pseudocolour table with one index load followed by a stream of reads.

Top module: `pal_ramdac`

## Requirements
- R1: A write to offset 0 loads the entry index from data bits 31:24 and sets the component phase to red.
- R2: A write to offset 4 stores data bits 31:24 into the component of entry[index] selected by the phase, and advances the phase from red to green to blue. Bits 23:0 are not used.
- R3: An access made in the blue phase returns the phase to red and increments the index by one, with 255 wrapping to 0.
- R4: A write to offset 12 stores into overlay entry 256 + index[1:0] under the same phase and increment rules.
- R5: A read, at any offset, places the current-phase component of pseudocolour entry[index] on read data bits 31:24, with bits 23:0 zero, in the cycle after the read strobe. The read then advances the phase and index exactly as a write does.
- R6: After reset every component is zero, except entries 255, 256 and 258, which are white (255,255,255). The index, the phase and the read data are also zero.
- R7: A write to any offset other than 0, 4 or 12 changes neither the table, the index nor the phase.
- R8: With overlay select low, the pixel port returns entry[pixel] as {R,G,B} on the clock after the inputs are presented. With overlay select high, it returns overlay entry 256 + select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (ignored when bus_wr is high) |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pix_idx | input | 8 | Pseudocolour pixel value |
| pix_ovl_en | input | 1 | Selects an overlay entry instead of pix_idx |
| pix_ovl_sel | input | 2 | Overlay entry number |
| pix_rgb | output | 24 | Looked-up colour {R,G,B}, one cycle latency |

## Verification
The bench builds the block with its default parameters: 8-bit components, an 8-bit index, 4 overlay entries and a 32-bit bus. At these values the index wrap from 255 to 0 takes only one address load and three writes to reach. Every overlay entry and every white reset entry can be checked directly through the pixel port. The byte lanes below the component field carry non-zero data, which shows that only the top byte is used.

// File: rtl/pal_pkg.sv
package pal_pkg;

   typedef enum logic [1:0] {PH_R = 2'd0, PH_G = 2'd1, PH_B = 2'd2} pal_phase_e;

   function automatic pal_phase_e phase_next(pal_phase_e p);
      case (p)
         PH_R:    return PH_G;
         PH_G:    return PH_B;
         default: return PH_R;
      endcase
   endfunction

   // slot number of a component inside a packed {R,G,B} entry, counted from the LSB
   function automatic int phase_slot(pal_phase_e p);
      case (p)
         PH_R:    return 2;
         PH_G:    return 1;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
   import pal_pkg::*;
#(
   parameter int AW     = 4,
   parameter int DW     = 32,
   parameter int CW     = 8,
   parameter int IDX_W  = 8,
   parameter int OVL_W  = 2,
   parameter int EW     = 9,
   parameter logic [AW-1:0] OFS_ADDR = 0,
   parameter logic [AW-1:0] OFS_DATA = 4,
   parameter logic [AW-1:0] OFS_OVL  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [CW-1:0]    rd_comp,
   output logic [IDX_W-1:0] idx,
   output pal_phase_e       phase,
   output logic             tbl_we,
   output logic [EW-1:0]    tbl_waddr,
   output logic [CW-1:0]    tbl_wdata
);
   localparam int NPAL = 1 << IDX_W;

   logic is_addr, is_data, is_ovl, is_rd, step;

   assign is_addr = bus_wr && (bus_addr == OFS_ADDR);
   assign is_data = bus_wr && (bus_addr == OFS_DATA);
   assign is_ovl  = bus_wr && (bus_addr == OFS_OVL);
   assign is_rd   = bus_rd && !bus_wr;
   assign step    = is_data || is_ovl || is_rd;

   assign tbl_we    = is_data || is_ovl;
   assign tbl_waddr = is_ovl ? EW'(NPAL + int'(idx[OVL_W-1:0])) : EW'(idx);
   assign tbl_wdata = bus_wdata[DW-1 -: CW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx   <= '0;
         phase <= PH_R;
      end else if (is_addr) begin
         idx   <= bus_wdata[DW-1 -: IDX_W];
         phase <= PH_R;
      end else if (step) begin
         phase <= phase_next(phase);
         if (phase == PH_B) idx <= idx + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (is_rd) bus_rdata <= {rd_comp, {(DW-CW){1'b0}}};
   end

   // R1: an address write loads the index and restarts at red
   a_r1_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
      is_addr |=> (idx == $past(bus_wdata[DW-1 -: IDX_W])) && (phase == PH_R));

   // R2: red and green accesses move the phase on and keep the index
   a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && phase != PH_B) |=> $stable(idx) && (phase != PH_R));

   // R3: a blue access returns to red and bumps the index modulo 2^IDX_W
   a_r3_wrap_incr: assert property (@(posedge clk) disable iff (!rst_n)
      (step && phase == PH_B) |=> (phase == PH_R) && (idx == IDX_W'($past(idx) + 1)));

   // R7: writes to unused offsets leave the sequencer untouched
   a_r7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !is_addr && !is_data && !is_ovl) |=> $stable(idx) && $stable(phase));

   // R5: read data carries nothing below the component field
   a_r5_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> (bus_rdata[DW-CW-1:0] == '0));
endmodule

// File: rtl/pal_store.sv
module pal_store
   import pal_pkg::*;
#(
   parameter int CW    = 8,
   parameter int IDX_W = 8,
   parameter int OVL_N = 4,
   parameter int EW    = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [EW-1:0]    waddr,
   input  pal_phase_e       wphase,
   input  logic [CW-1:0]    wdata,
   input  logic [IDX_W-1:0] bus_idx,
   input  pal_phase_e       bus_phase,
   output logic [CW-1:0]    bus_comp,
   input  logic [EW-1:0]    pix_addr,
   output logic [3*CW-1:0]  pix_ent
);
   localparam int NPAL = 1 << IDX_W;
   localparam int NENT = NPAL + OVL_N;

   logic [3*CW-1:0] ent_arr [NENT];

   for (genvar e = 0; e < NENT; e++) begin : g_ent
      // last pseudocolour entry and overlay entries 0 and 2 start white
      localparam bit WHITE = (e == NPAL - 1) || (e == NPAL) || (e == NPAL + 2);
      logic [3*CW-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q <= WHITE ? {(3*CW){1'b1}} : '0;
         else if (we && (waddr == EW'(e)))
            ent_q[phase_slot(wphase)*CW +: CW] <= wdata;
      end
      assign ent_arr[e] = ent_q;
   end

   logic [3*CW-1:0] bus_ent;
   assign bus_ent  = ent_arr[EW'(bus_idx)];
   assign bus_comp = bus_ent[phase_slot(bus_phase)*CW +: CW];
   assign pix_ent  = ent_arr[pix_addr];

   // R4: writes never land past the overlay region
   a_r4_waddr_range: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < NENT));
endmodule

// File: rtl/pal_lookup.sv
module pal_lookup #(
   parameter int CW    = 8,
   parameter int IDX_W = 8,
   parameter int OVL_W = 2,
   parameter int EW    = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] pix_idx,
   input  logic             pix_ovl_en,
   input  logic [OVL_W-1:0] pix_ovl_sel,
   output logic [EW-1:0]    pix_addr,
   input  logic [3*CW-1:0]  pix_ent,
   output logic [3*CW-1:0]  pix_rgb
);
   localparam int NPAL = 1 << IDX_W;

   assign pix_addr = pix_ovl_en ? EW'(NPAL + int'(pix_ovl_sel)) : EW'(pix_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pix_rgb <= '0;
      else        pix_rgb <= pix_ent;
   end

   // R8: the overlay select always reaches the overlay region
   a_r8_ovl_addr: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ovl_en |-> (int'(pix_addr) >= NPAL));
endmodule

// File: rtl/pal_ramdac.sv
module pal_ramdac
   import pal_pkg::*;
#(
   parameter int AW    = 4,
   parameter int DW    = 32,
   parameter int CW    = 8,
   parameter int IDX_W = 8,
   parameter int OVL_N = 4,
   parameter logic [AW-1:0] OFS_ADDR = 0,
   parameter logic [AW-1:0] OFS_DATA = 4,
   parameter logic [AW-1:0] OFS_OVL  = 12,
   localparam int OVL_W = $clog2(OVL_N),
   localparam int EW    = $clog2((1 << IDX_W) + OVL_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [IDX_W-1:0] pix_idx,
   input  logic             pix_ovl_en,
   input  logic [OVL_W-1:0] pix_ovl_sel,
   output logic [3*CW-1:0]  pix_rgb
);
   if (CW > DW || IDX_W > DW) begin : g_bad_width
      $error("pal_ramdac: component and index fields must fit the bus");
   end
   if (OVL_N < 4 || (1 << OVL_W) != OVL_N) begin : g_bad_ovl
      $error("pal_ramdac: overlay count must be a power of two, at least 4");
   end

   logic [IDX_W-1:0] idx;
   pal_phase_e       phase;
   logic             tbl_we;
   logic [EW-1:0]    tbl_waddr;
   logic [CW-1:0]    tbl_wdata;
   logic [CW-1:0]    rd_comp;
   logic [EW-1:0]    pix_addr;
   logic [3*CW-1:0]  pix_ent;

   pal_seq #(
      .AW(AW), .DW(DW), .CW(CW), .IDX_W(IDX_W), .OVL_W(OVL_W), .EW(EW),
      .OFS_ADDR(OFS_ADDR), .OFS_DATA(OFS_DATA), .OFS_OVL(OFS_OVL)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rd_comp(rd_comp), .idx(idx), .phase(phase), .tbl_we(tbl_we),
      .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata)
   );

   pal_store #(.CW(CW), .IDX_W(IDX_W), .OVL_N(OVL_N), .EW(EW)) u_store (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_waddr),
      .wphase(phase), .wdata(tbl_wdata), .bus_idx(idx), .bus_phase(phase),
      .bus_comp(rd_comp), .pix_addr(pix_addr), .pix_ent(pix_ent)
   );

   pal_lookup #(.CW(CW), .IDX_W(IDX_W), .OVL_W(OVL_W), .EW(EW)) u_lookup (
      .clk(clk), .rst_n(rst_n), .pix_idx(pix_idx), .pix_ovl_en(pix_ovl_en),
      .pix_ovl_sel(pix_ovl_sel), .pix_addr(pix_addr), .pix_ent(pix_ent),
      .pix_rgb(pix_rgb)
   );
endmodule

// File: tb/tb_pal_ramdac.sv
module tb_pal_ramdac;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pix_idx = '0;
   logic        pix_ovl_en = 1'b0;
   logic [1:0]  pix_ovl_sel = '0;
   logic [23:0] pix_rgb;

   int checks = 0, failures = 0;
   logic [7:0] mp [260][3];
   int midx = 0, mph = 0;

   always #2.5 clk = ~clk;

   pal_ramdac dut (.*);

   // op: 0 write, 1 read and compare, 2 pixel lookup and compare
   // fields: {op[1:0], addr[3:0], pad[1:0], data[31:0]}
   localparam int NV = 17;
   localparam logic [39:0] VEC [NV] = '{
      {2'd0, 4'd0,  2'd0, 32'h05FFFFFF},
      {2'd0, 4'd4,  2'd0, 32'h11ABCDEF},
      {2'd0, 4'd4,  2'd0, 32'h22ABCDEF},
      {2'd0, 4'd4,  2'd0, 32'h33ABCDEF},
      {2'd2, 4'd0,  2'd0, 32'h00000005},
      {2'd0, 4'd0,  2'd0, 32'h05000000},
      {2'd1, 4'd4,  2'd0, 32'h0},
      {2'd1, 4'd4,  2'd0, 32'h0},
      {2'd1, 4'd0,  2'd0, 32'h0},
      {2'd2, 4'd0,  2'd0, 32'h00000006},
      {2'd0, 4'd0,  2'd0, 32'h06000000},
      {2'd0, 4'd12, 2'd0, 32'hAA000001},
      {2'd0, 4'd12, 2'd0, 32'hBB000001},
      {2'd0, 4'd12, 2'd0, 32'hCC000001},
      {2'd2, 4'd0,  2'd0, 32'h00000500},
      {2'd0, 4'd8,  2'd0, 32'hFFFFFFFF},
      {2'd0, 4'd4,  2'd0, 32'h44000000}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void model_step();
      if (mph == 2) begin mph = 0; midx = (midx + 1) % 256; end
      else mph++;
   endfunction

   task automatic do_write(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == 4'd0) begin midx = d[31:24]; mph = 0; end
      else if (a == 4'd4) begin mp[midx][mph] = d[31:24]; model_step(); end
      else if (a == 4'd12) begin mp[256 + (midx % 4)][mph] = d[31:24]; model_step(); end
   endtask

   task automatic do_read(logic [3:0] a, string req);
      logic [31:0] exp;
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      exp = {mp[midx][mph], 24'h0};
      @(negedge clk);
      bus_rd = 1'b0;
      check(req, bus_rdata, exp);
      model_step();
   endtask

   task automatic do_pix(logic [7:0] p, logic oe, logic [1:0] os, string req);
      int e;
      @(negedge clk);
      pix_idx = p; pix_ovl_en = oe; pix_ovl_sel = os;
      e = oe ? 256 + int'(os) : int'(p);
      @(negedge clk);
      check(req, {8'h0, pix_rgb}, {8'h0, mp[e][0], mp[e][1], mp[e][2]});
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int e = 0; e < 260; e++)
         for (int c = 0; c < 3; c++)
            mp[e][c] = (e == 255 || e == 256 || e == 258) ? 8'hFF : 8'h00;
      #12 rst_n = 1'b1;
      // R6: reset state at the ports
      check("R6 rdata", bus_rdata, 32'h0);
      do_pix(8'd0,   1'b0, 2'd0, "R6 entry0");
      do_pix(8'd255, 1'b0, 2'd0, "R6 entry255");
      do_pix(8'd0,   1'b1, 2'd0, "R6 ovl0");
      do_pix(8'd0,   1'b1, 2'd1, "R6 ovl1");
      do_pix(8'd0,   1'b1, 2'd2, "R6 ovl2");
      do_pix(8'd0,   1'b1, 2'd3, "R6 ovl3");
      // R6: index 0, red phase: three reads walk entry 0 then index 1
      do_read(4'd4, "R6 r5 read entry0");
      do_read(4'd4, "R6 r5 read entry0");
      do_read(4'd4, "R6 r5 read entry0");
      do_read(4'd4, "R6 r3 read entry1");
      // table walk: R1 R2 R3 R4 R5 R7 R8
      for (int v = 0; v < NV; v++) begin
         case (VEC[v][39:38])
            2'd0: do_write(VEC[v][37:34], VEC[v][31:0]);
            2'd1: do_read(VEC[v][37:34], "R5 R2 readback");
            default: do_pix(VEC[v][7:0], VEC[v][8], VEC[v][10:9], "R8 R4 lookup");
         endcase
      end
      // R7: the ignored write did not disturb the sequence (entry 7 red)
      do_pix(8'd7, 1'b0, 2'd0, "R7 after ignored write");
      do_pix(8'd0, 1'b1, 2'd2, "R4 overlay 258");
      // R3: wrap from 255 to 0
      do_write(4'd0, 32'hFF000000);
      do_write(4'd4, 32'h01000000);
      do_write(4'd4, 32'h02000000);
      do_write(4'd4, 32'h03000000);
      do_write(4'd4, 32'h09000000);
      do_pix(8'd255, 1'b0, 2'd0, "R3 entry255");
      do_pix(8'd0,   1'b0, 2'd0, "R3 wrapped to entry0");
      // R4: overlay uses index low bits; index 0x07 -> overlay 3
      do_write(4'd0, 32'h07000000);
      do_write(4'd12, 32'h5A000000);
      do_pix(8'd0, 1'b1, 2'd3, "R4 overlay index bits");
      // R1: reload mid-sequence restarts red; R5 read after reload
      do_write(4'd0, 32'h05000000);
      do_read(4'd0, "R1 reload restart red");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule